// File: doc/BRIEF.md
# Debounced Event-Sense Parallel Port

This block provides 24 general-purpose digital I/O lines grouped as three 8-bit ports behind a byte-wide register bus. Every port has an output latch that drives its outgoing lines. A read of a port returns the level of its incoming lines, inverted. After reset the block runs in a basic mode, in which only the three port registers exist.

Software can switch the block into an enhanced mode. It does so with a fixed series of four writes to a key register, and these must be the first accesses after reset. Enhanced mode adds a bank-select register and two banks of extra registers. The bank-select register also holds one write-inhibit bit per port. The event bank holds per-port change-detect enables and sticky event flags, which drive one interrupt line. The debounce bank holds per-port filter enables, a hold count and a choice of filter tick rate. A filtered line takes a new level only after that level has stayed steady for the programmed number of ticks.

Each incoming line passes through a two-stage synchronizer, then through its filter, which is bypassed when the port's debounce is off. Both the read path and the change detector take their input from the filter output.

Top module: `dio_event_port`

## Requirements
- R1: After reset every output latch is 00h, `irq` is low, the block is in basic mode, and all enable, inhibit and configuration fields are zero.
- R2: A write to offset 78h, 79h or 7Ah while the data bank is in effect stores the byte in the latch of port 0, 1 or 2, and `pin_out` shows it from the next cycle. Port p drives `pin_out[8p+7:8p]`. `pin_out` changes at no other time.
- R3: While the data bank is in effect, a read of offset 78h, 79h or 7Ah returns the bitwise inverse of the filtered levels of port 0, 1 or 2. With debounce off, this follows `pin_in` within 3 cycles.
- R4: Enhanced mode becomes active when the first four bus accesses after reset are writes to offset 7Dh carrying 07h, 0Dh, 06h and 12h, in that order. Idle cycles between them are allowed. The mode stays active until reset.
- R5: Any read, or any write that does not match the next expected key, ends the unlock attempt until the next reset. In basic mode the data bank is always in effect, offset 7Fh reads 00h, and writes to 7Fh have no effect.
- R6: In enhanced mode, bits 7:6 of offset 7Fh choose the bank: 00 data, 01 event, 10 debounce. Bank 11 reads 00h at offsets 78h to 7Bh and ignores writes there. Port latches can be written only in the data bank.
- R7: Bits 2:0 of offset 7Fh are per-port write inhibits, with bit p for port p. While bit p is set, writes to port p's latch have no effect. Offset 7Fh reads back its bank and inhibit bits.
- R8: In the debounce bank, offset 78h bits 2:0 enable filtering per port, and offset 79h sets the hold count N. A filtered line takes a new level only after the synchronized level has differed from it on N consecutive filter ticks. A shorter excursion leaves it unchanged.
- R9: In the event bank, offset 78h bits 2:0 enable change detection per port. Any change of a filtered line in an enabled port sets that port's flag. Flags read at offset 79h bits 2:0, and bit 7 is the OR of all flags. A disabled port sets no flag.
- R10: `irq` is high exactly while some event flag is set. Writing 1 to a flag bit at offset 79h in the event bank clears it, and otherwise a flag stays set.
- R11: Offset 7Bh bits 1:0 in the debounce bank choose the filter tick period, 4^sel clock cycles (1, 4, 16 or 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 24 | Incoming line levels, port p at bits 8p+7:8p |
| pin_out | output | 24 | Output latch contents, port p at bits 8p+7:8p |
| irq | output | 1 | Event interrupt |

## Verification
Software sees the unlock state only through offset 7Fh. If the detector wrongly stays locked or wrongly unlocks, this shows on the first read of 7Fh after the key sequence, or on the first write that should be inhibited. A bank decode fault appears on the next port write as an unexpected change of `pin_out`, or as a wrong read-back. A filter count that is off by one, or a wrong tick prescale, moves the moment a new level is read. The bench therefore reads both before and after the expected settling point. Flag faults show on `irq` in the cycle after the stimulus.

// File: rtl/dio_pkg.sv
package dio_pkg;

    // Register offsets; the three port offsets are consecutive from OFS_PORT0
    localparam logic [7:0] OFS_PORT0 = 8'h78;
    localparam logic [7:0] OFS_AUX   = 8'h7B;
    localparam logic [7:0] OFS_KEY   = 8'h7D;
    localparam logic [7:0] OFS_BANK  = 8'h7F;

    localparam int KEY_LEN = 4;
    localparam int SEL_W   = 2;
    localparam int PRE_W   = 2 * ((1 << SEL_W) - 1);

    typedef enum logic [1:0] {
        BANK_DATA = 2'b00,
        BANK_EVT  = 2'b01,
        BANK_DEB  = 2'b10,
        BANK_NONE = 2'b11
    } bank_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_req_t;

    // Expected key byte for each step of the unlock series
    function automatic logic [7:0] key_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h07;
            3'd1:    return 8'h0D;
            3'd2:    return 8'h06;
            default: return 8'h12;
        endcase
    endfunction

    // Low bits of the prescaler that must be zero for a filter tick
    function automatic logic [PRE_W-1:0] tick_mask(input logic [SEL_W-1:0] sel);
        return PRE_W'((1 << (2 * int'(sel))) - 1);
    endfunction

endpackage

// File: rtl/dio_unlock.sv
module dio_unlock
    import dio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     enh_mode,
    output logic     unlock_dead
);
    logic [2:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q      <= '0;
            enh_mode    <= 1'b0;
            unlock_dead <= 1'b0;
        end else if (!enh_mode && !unlock_dead && (req.wr || req.rd)) begin
            if (req.wr && req.addr == OFS_KEY && req.data == key_byte(step_q)) begin
                if (step_q == 3'(KEY_LEN - 1))
                    enh_mode <= 1'b1;
                else
                    step_q <= step_q + 3'd1;
            end else begin
                unlock_dead <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dio_filter.sv
module dio_filter #(
    parameter int PW    = 8,
    parameter int DUR_W = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    pin,
    input  logic             en,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur,
    output logic [PW-1:0]    filt
);
    localparam int CW = DUR_W + 1;

    logic [SYNC-1:0][PW-1:0] sync_q;
    logic [PW-1:0]           lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= pin;
            for (int s = 1; s < SYNC; s++)
                sync_q[s] <= sync_q[s-1];
        end
    end

    assign lvl = sync_q[SYNC-1];

    for (genvar b = 0; b < PW; b++) begin : g_bit
        logic [DUR_W-1:0] cnt_q;
        logic             out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                out_q <= 1'b0;
            end else if (!en) begin
                cnt_q <= '0;
                out_q <= lvl[b];
            end else if (lvl[b] == out_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (CW'(cnt_q) + CW'(1) >= CW'(dur)) begin
                    out_q <= lvl[b];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + DUR_W'(1);
                end
            end
        end

        assign filt[b] = out_q;
    end
endmodule

// File: rtl/dio_evt.sv
module dio_evt #(
    parameter int NPORT = 3,
    parameter int PW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT*PW-1:0] filt,
    input  logic [NPORT-1:0]    en,
    input  logic [NPORT-1:0]    clr,
    output logic [NPORT-1:0]    flags
);
    logic [NPORT*PW-1:0] prev_q;
    logic [NPORT-1:0]    chg;

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            chg[p] = |(filt[p*PW +: PW] ^ prev_q[p*PW +: PW]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flags  <= '0;
        end else begin
            prev_q <= filt;
            flags  <= (flags & ~clr) | (chg & en);
        end
    end
endmodule

// File: rtl/dio_event_port.sv
module dio_event_port
    import dio_pkg::*;
#(
    parameter int NPORT       = 3,
    parameter int PW          = 8,
    parameter int DUR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NPORT*PW-1:0] pin_in,
    output logic [NPORT*PW-1:0] pin_out,
    output logic                irq
);
    bus_req_t                  req;
    logic                      enh_mode;
    logic                      unlock_dead;
    bank_e                     bank_q;
    bank_e                     bank_eff;
    logic [NPORT-1:0]          inhibit_q;
    logic [NPORT-1:0][PW-1:0]  latch_q;
    logic [NPORT-1:0]          ev_en_q;
    logic [NPORT-1:0]          deb_en_q;
    logic [DUR_W-1:0]          dur_q;
    logic [SEL_W-1:0]          clksel_q;
    logic [PRE_W-1:0]          pre_q;
    logic                      tick;
    logic [NPORT*PW-1:0]       filt;
    logic [NPORT-1:0]          ev_flags;
    logic [NPORT-1:0]          ev_clr;
    logic [7:0]                rd_mux;

    always_comb begin
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.addr = bus_addr;
        req.data = bus_wdata;
    end

    dio_unlock u_unlock (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .enh_mode   (enh_mode),
        .unlock_dead(unlock_dead)
    );

    assign bank_eff = enh_mode ? bank_q : BANK_DATA;

    // Configuration and latch writes
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            bank_q    <= BANK_DATA;
            inhibit_q <= '0;
            ev_en_q   <= '0;
            deb_en_q  <= '0;
            dur_q     <= '0;
            clksel_q  <= '0;
        end else if (bus_wr) begin
            if (enh_mode && bus_addr == OFS_BANK) begin
                bank_q    <= bank_e'(bus_wdata[7:6]);
                inhibit_q <= bus_wdata[NPORT-1:0];
            end
            case (bank_eff)
                BANK_DATA: begin
                    for (int p = 0; p < NPORT; p++)
                        if (bus_addr == OFS_PORT0 + 8'(p) && !inhibit_q[p])
                            latch_q[p] <= bus_wdata[PW-1:0];
                end
                BANK_EVT: begin
                    if (bus_addr == OFS_PORT0)
                        ev_en_q <= bus_wdata[NPORT-1:0];
                end
                BANK_DEB: begin
                    if (bus_addr == OFS_PORT0)
                        deb_en_q <= bus_wdata[NPORT-1:0];
                    if (bus_addr == OFS_PORT0 + 8'd1)
                        dur_q <= bus_wdata[DUR_W-1:0];
                    if (bus_addr == OFS_AUX)
                        clksel_q <= bus_wdata[SEL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign pin_out = latch_q;

    // Filter tick prescaler
    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    assign tick = (pre_q & tick_mask(clksel_q)) == '0;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dio_filter #(
            .PW   (PW),
            .DUR_W(DUR_W),
            .SYNC (SYNC_STAGES)
        ) u_filter (
            .clk (clk),
            .rst (rst),
            .pin (pin_in[p*PW +: PW]),
            .en  (deb_en_q[p]),
            .tick(tick),
            .dur (dur_q),
            .filt(filt[p*PW +: PW])
        );
    end

    assign ev_clr = (bus_wr && bank_eff == BANK_EVT && bus_addr == OFS_PORT0 + 8'd1)
                  ? bus_wdata[NPORT-1:0] : '0;

    dio_evt #(
        .NPORT(NPORT),
        .PW   (PW)
    ) u_evt (
        .clk  (clk),
        .rst  (rst),
        .filt (filt),
        .en   (ev_en_q),
        .clr  (ev_clr),
        .flags(ev_flags)
    );

    assign irq = |ev_flags;

    // Read path
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_BANK) begin
            if (enh_mode) begin
                rd_mux[7:6]       = bank_q;
                rd_mux[NPORT-1:0] = inhibit_q;
            end
        end else begin
            case (bank_eff)
                BANK_DATA: begin
                    for (int p = 0; p < NPORT; p++)
                        if (bus_addr == OFS_PORT0 + 8'(p))
                            rd_mux[PW-1:0] = ~filt[p*PW +: PW];
                end
                BANK_EVT: begin
                    if (bus_addr == OFS_PORT0)
                        rd_mux[NPORT-1:0] = ev_en_q;
                    if (bus_addr == OFS_PORT0 + 8'd1) begin
                        rd_mux[NPORT-1:0] = ev_flags;
                        rd_mux[7]         = |ev_flags;
                    end
                end
                BANK_DEB: begin
                    if (bus_addr == OFS_PORT0)
                        rd_mux[NPORT-1:0] = deb_en_q;
                    if (bus_addr == OFS_PORT0 + 8'd1)
                        rd_mux[DUR_W-1:0] = dur_q;
                    if (bus_addr == OFS_AUX)
                        rd_mux[SEL_W-1:0] = clksel_q;
                end
                default: ;
            endcase
        end
    end

    assign bus_rdata = rd_mux;
endmodule

// File: rtl/dio_event_port_chk.sv
module dio_event_port_chk #(
    parameter int NPORT = 3,
    parameter int PW    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [7:0]          bus_addr,
    input logic [NPORT*PW-1:0] pin_out,
    input logic                irq,
    input logic                enh_mode,
    input logic                unlock_dead,
    input logic [NPORT-1:0]    flags,
    input logic [NPORT-1:0]    inhibit,
    input logic [1:0]          bank_eff
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pin_out == '0 && !irq && !enh_mode));

    // R2
    latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pin_out));

    // R4
    enh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        enh_mode |=> enh_mode);

    // R5
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        unlock_dead |=> (unlock_dead && !enh_mode));

    // R7
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bank_eff == 2'b00 && inhibit[0] && bus_addr == 8'h78)
        |=> $stable(pin_out[PW-1:0]));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
endmodule

bind dio_event_port dio_event_port_chk #(
    .NPORT(NPORT),
    .PW   (PW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .pin_out    (pin_out),
    .irq        (irq),
    .enh_mode   (enh_mode),
    .unlock_dead(unlock_dead),
    .flags      (ev_flags),
    .inhibit    (inhibit_q),
    .bank_eff   (bank_eff)
);

// File: tb/test_dio_event_port.sv
module test_dio_event_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = 24'h0;
    logic [23:0] pin_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    dio_event_port i_dio_event_port (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .irq      (irq)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ticks(3);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issues a read and queues the expected byte for the monitor
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic unlock();
        wr(8'h7D, 8'h07);
        wr(8'h7D, 8'h0D);
        wr(8'h7D, 8'h06);
        wr(8'h7D, 8'h12);
    endtask

    // Monitor: compares read data with the queued expectations
    always @(posedge clk) begin
        #2;
        if (bus_rd) begin
            n_cmp++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with nothing expected, actual %h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ticks(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_out", pin_out, 24'h0);
        check("R1 irq", {23'h0, irq}, 24'h0);

        // R5 an access before the key series locks the block in basic mode
        rd(8'h7F, 8'h00, "R5 bank reg reads zero in basic");
        rd(8'h78, 8'hFF, "R3 port0 inverted idle");
        unlock();
        wr(8'h7F, 8'h07);
        wr(8'h78, 8'hA5);
        check("R5 inhibit ignored in basic / R2 latch", {16'h0, pin_out[7:0]}, 24'h0000A5);
        rd(8'h7F, 8'h00, "R5 still basic after late key");

        // R3 inverted read of all ports
        pin_in = 24'h3C810F;
        ticks(5);
        rd(8'h78, 8'hF0, "R3 port0");
        rd(8'h79, 8'h7E, "R3 port1");
        rd(8'h7A, 8'hC3, "R3 port2");
        wr(8'h7A, 8'h5A);
        check("R2 port2 latch", {16'h0, pin_out[23:16]}, 24'h00005A);

        // R4 proper unlock right after reset
        do_reset();
        check("R1 latches after reset", pin_out, 24'h0);
        unlock();
        wr(8'h7F, 8'h40);
        rd(8'h7F, 8'h40, "R4 bank reg readable");

        // R6 port offsets in event bank do not touch latches
        wr(8'h78, 8'h33);
        check("R6 no latch write in event bank", pin_out, 24'h0);
        rd(8'h78, 8'h03, "R6 event enable readback");
        wr(8'h78, 8'h00);

        // R7 per-port write inhibit
        wr(8'h7F, 8'h02);
        wr(8'h79, 8'h11);
        wr(8'h78, 8'h22);
        check("R7 port1 inhibited, port0 written", pin_out, 24'h000022);
        rd(8'h7F, 8'h02, "R7 inhibit readback");

        // R6 undefined bank
        wr(8'h7F, 8'hC0);
        wr(8'h78, 8'h99);
        check("R6 bank3 write ignored", pin_out, 24'h000022);
        rd(8'h78, 8'h00, "R6 bank3 reads zero");

        // R9 / R10 event flags and interrupt
        wr(8'h7F, 8'h40);
        wr(8'h78, 8'h01);
        rd(8'h79, 8'h00, "R9 no flags yet");
        pin_in = 24'h3C810E;
        ticks(6);
        rd(8'h79, 8'h81, "R9 port0 flag and global");
        check("R10 irq raised", {23'h0, irq}, 24'h1);
        pin_in = 24'h3C800E;
        ticks(6);
        rd(8'h79, 8'h81, "R9 disabled port1 sets no flag");
        wr(8'h79, 8'h01);
        check("R10 irq cleared by write-one", {23'h0, irq}, 24'h0);
        rd(8'h79, 8'h00, "R10 flag cleared");

        // R8 debounce on port0, hold 5 ticks, tick every cycle
        wr(8'h7F, 8'h80);
        wr(8'h79, 8'h05);
        wr(8'h7B, 8'h00);
        wr(8'h78, 8'h01);
        rd(8'h79, 8'h05, "R8 duration readback");
        wr(8'h7F, 8'h00);
        rd(8'h78, 8'hF1, "R8 settled level");
        pin_in[7:0] = 8'h1E;
        ticks(3);
        pin_in[7:0] = 8'h0E;
        ticks(20);
        rd(8'h78, 8'hF1, "R8 short glitch rejected");
        pin_in[7:0] = 8'h1E;
        ticks(3);
        rd(8'h78, 8'hF1, "R8 not yet passed");
        ticks(12);
        rd(8'h78, 8'hE1, "R8 passed after hold");

        // R11 slower tick: 16 cycles per tick
        wr(8'h7F, 8'h80);
        wr(8'h7B, 8'h02);
        rd(8'h7B, 8'h02, "R11 clock select readback");
        wr(8'h7F, 8'h00);
        pin_in[7:0] = 8'h0E;
        ticks(40);
        rd(8'h78, 8'hE1, "R11 still held at slow tick");
        ticks(80);
        rd(8'h78, 8'hF1, "R11 passed at slow tick");

        ticks(3);
        if (q_exp.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q_exp.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule